// File: doc/BRIEF.md
# Linked-List DMA Channel Engine

This block is one DMA channel. It copies elements from a source address to a destination address over a simple request/acknowledge memory port. A single 32-bit control word holds the element count, the source and destination element widths, the two address-increment flags and a completion-notify flag. Each element is one read followed by one write. After each element the count in the control word goes down by one. When the count reaches zero, the channel does one of two things. If the next-descriptor pointer is nonzero, it reloads itself from a four-word descriptor in memory. If the pointer is zero, it turns itself off. An external `go` level grants permission to start each element.

A host programs the five channel registers through a write port. The port takes a 3-bit selector: 0 source, 1 destination, 2 next-pointer, 3 control, 4 configuration. Configuration bit 0 enables the channel and bit 18 halts it. The memory port stays high from request to acknowledge. Element data travels right-justified on the 32-bit buses. Descriptor words are little-endian, so `mem_rdata[7:0]` is the byte at the lowest address.

The controller has four states. In IDLE it waits for an eligible channel and `go`. READ issues the source read and waits for its acknowledge. WRITE issues the destination write and waits for its acknowledge. FETCH reads the four descriptor words. The transitions are:
- start: IDLE to READ.
- read-done: READ to WRITE.
- element-done: WRITE to IDLE, taken when count remains or the pointer is zero.
- chain: WRITE to FETCH, taken on the last element with a nonzero pointer.
- reload-done: FETCH to IDLE, after the fourth descriptor word.

Top module: `lldma_chan`

## Requirements
- R1: After reset all five registers read zero, `mem_req` is low and `tc_pulse` is low.
- R2: A host write with selector 0..4 updates the matching register on the next edge, but only while the controller is in IDLE. A write at any other time leaves the register unchanged.
- R3: An element starts (IDLE to READ) only when `go` is 1, configuration bit 0 is 1, configuration bit 18 is 0 and control bits 11:0 are nonzero. Otherwise `mem_req` stays low, and a zero count leaves the enable bit set.
- R4: An element reads the source address with `mem_size` equal to control bits 20:18, giving 2^code bytes. It then writes the destination address with `mem_size` equal to control bits 23:21, carrying the read data zero-extended.
- R5: When control bit 26 is set, the source address advances by 2^(bits 20:18) after each read. When control bit 27 is set, the destination address advances by 2^(bits 23:21) after each write. A clear bit keeps that address fixed.
- R6: Each completed write lowers control bits 11:0 by one and leaves bits 31:12 unchanged.
- R7: When the count reaches zero and the next-pointer is zero, configuration bit 0 is cleared. The other configuration bits are kept.
- R8: When the count reaches zero and the next-pointer P is nonzero, the channel reads 32-bit words at P+0, P+4, P+12 and P+8, in that order. It loads them as source, destination, control and new pointer, and starts no element until all four reads are done.
- R9: One cycle after a completion, `tc_pulse` is high for exactly one cycle if bit 31 of the control word then in effect is set. After a reload, that is the newly loaded word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Register write strobe |
| host_sel | input | 3 | Register selector (0 src, 1 dst, 2 ptr, 3 ctrl, 4 cfg) |
| host_wdata | input | 32 | Register write data |
| go | input | 1 | Permission to start an element |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_size | output | 3 | log2 of the access size in bytes |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_ack | input | 1 | One-cycle acknowledge of the current request |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| src_q | output | ADDR_W | Current source address |
| dst_q | output | ADDR_W | Current destination address |
| ptr_q | output | ADDR_W | Current next-descriptor pointer |
| ctrl_q | output | 32 | Current control word |
| cfg_q | output | 32 | Current configuration word |
| tc_pulse | output | 1 | Terminal-count pulse |

## Verification
A table of single-segment transfers sweeps the width codes. It includes equal widths, narrow-to-wide (which shows zero-extension) and wide-to-narrow (which shows truncation). It also runs increment on both sides, source only and destination only. This separates a swapped increment flag or a wrong step size from a correct one. Two chained runs with opposite notify-bit settings tell reading bit 31 from the new control word apart from reading it from the old one. The logged read addresses expose any change in the descriptor fetch order. Directed cases cover a halted channel, a low `go`, a zero count, and a host write made while a request is outstanding.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_FETCH = 2'd3
    } lldma_state_e;

    localparam int SW_LSB    = 18;
    localparam int DW_LSB    = 21;
    localparam int SINC_BIT  = 26;
    localparam int DINC_BIT  = 27;
    localparam int NOTIFY_BIT = 31;
    localparam int EN_BIT    = 0;
    localparam int HALT_BIT  = 18;

    localparam logic [2:0] SEL_SRC  = 3'd0;
    localparam logic [2:0] SEL_DST  = 3'd1;
    localparam logic [2:0] SEL_PTR  = 3'd2;
    localparam logic [2:0] SEL_CTRL = 3'd3;
    localparam logic [2:0] SEL_CFG  = 3'd4;

    // Fetch step k reads these byte offsets; the pointer word comes last
    // so the base address stays valid for the whole fetch.
    function automatic logic [3:0] desc_offset(input logic [1:0] k);
        unique case (k)
            2'd0:    return 4'd0;
            2'd1:    return 4'd4;
            2'd2:    return 4'd12;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/lldma_regs.sv
module lldma_regs
    import lldma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic              src_step,
    input  logic              elem_done,
    input  logic              en_clear,
    input  logic              desc_we,
    input  logic [1:0]        desc_idx,
    input  logic [31:0]       desc_data,
    output logic [ADDR_W-1:0] src_r,
    output logic [ADDR_W-1:0] dst_r,
    output logic [ADDR_W-1:0] ptr_r,
    output logic [31:0]       ctrl_r,
    output logic [31:0]       cfg_r
);

    logic [ADDR_W-1:0] s_inc;
    logic [ADDR_W-1:0] d_inc;

    assign s_inc = ADDR_W'(1) << ctrl_r[SW_LSB +: 3];
    assign d_inc = ADDR_W'(1) << ctrl_r[DW_LSB +: 3];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_r  <= '0;
            dst_r  <= '0;
            ptr_r  <= '0;
            ctrl_r <= '0;
            cfg_r  <= '0;
        end else begin
            if (wr_en) begin
                unique case (wr_sel)
                    SEL_SRC:  src_r  <= wr_data[ADDR_W-1:0];
                    SEL_DST:  dst_r  <= wr_data[ADDR_W-1:0];
                    SEL_PTR:  ptr_r  <= wr_data[ADDR_W-1:0];
                    SEL_CTRL: ctrl_r <= wr_data;
                    SEL_CFG:  cfg_r  <= wr_data;
                    default:  ;
                endcase
            end
            if (src_step && ctrl_r[SINC_BIT])
                src_r <= src_r + s_inc;
            if (elem_done) begin
                if (ctrl_r[DINC_BIT])
                    dst_r <= dst_r + d_inc;
                ctrl_r[CNT_W-1:0] <= ctrl_r[CNT_W-1:0] - CNT_W'(1);
            end
            if (en_clear)
                cfg_r[EN_BIT] <= 1'b0;
            if (desc_we) begin
                unique case (desc_idx)
                    2'd0:    src_r  <= desc_data[ADDR_W-1:0];
                    2'd1:    dst_r  <= desc_data[ADDR_W-1:0];
                    2'd2:    ctrl_r <= desc_data;
                    default: ptr_r  <= desc_data[ADDR_W-1:0];
                endcase
            end
        end
    end

    // R5: a read with the source increment flag clear leaves the source fixed
    a_r5_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (src_step && !ctrl_r[SINC_BIT] && !desc_we && !wr_en) |=> $stable(src_r));

    // R6: one element lowers the count by one, upper control bits kept
    a_r6_count_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_done && !wr_en && !desc_we) |=>
        (ctrl_r[CNT_W-1:0] == $past(ctrl_r[CNT_W-1:0]) - CNT_W'(1)) &&
        (ctrl_r[31:CNT_W] == $past(ctrl_r[31:CNT_W])));

endmodule

// File: rtl/lldma_fsm.sv
module lldma_fsm
    import lldma_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic         chan_en,
    input  logic         chan_halt,
    input  logic         cnt_nz,
    input  logic         cnt_last,
    input  logic         ptr_nz,
    input  logic         notify,
    input  logic         mem_ack,
    output lldma_state_e state,
    output logic [1:0]   fetch_idx,
    output logic         src_step,
    output logic         elem_done,
    output logic         en_clear,
    output logic         desc_we,
    output logic         tc_pulse
);

    lldma_state_e state_nx;
    logic         fetch_last;

    assign fetch_last = (fetch_idx == 2'd3);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (go && chan_en && !chan_halt && cnt_nz) state_nx = ST_READ;
            ST_READ:  if (mem_ack) state_nx = ST_WRITE;
            ST_WRITE: if (mem_ack) state_nx = (cnt_last && ptr_nz) ? ST_FETCH : ST_IDLE;
            ST_FETCH: if (mem_ack && fetch_last) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            fetch_idx <= 2'd0;
        end else begin
            state <= state_nx;
            if (state != ST_FETCH)
                fetch_idx <= 2'd0;
            else if (mem_ack)
                fetch_idx <= fetch_idx + 2'd1;
        end
    end

    always_comb begin
        src_step  = 1'b0;
        elem_done = 1'b0;
        en_clear  = 1'b0;
        desc_we   = 1'b0;
        unique case (state)
            ST_READ:  src_step = mem_ack;
            ST_WRITE: begin
                elem_done = mem_ack;
                en_clear  = mem_ack && cnt_last && !ptr_nz;
            end
            ST_FETCH: desc_we = mem_ack;
            default:  ;
        endcase
    end

    // Completion pulse: registered, so it follows the completing edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tc_pulse <= 1'b0;
        else
            tc_pulse <= (en_clear && notify) ||
                        (state == ST_FETCH && mem_ack && fetch_last && notify);
    end

    // R3: a halted channel never leaves IDLE
    a_r3_halt_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && chan_halt) |=> state == ST_IDLE);

    // R8: once fetching, no element starts until the fetch ends
    a_r8_fetch_whole: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (state == ST_FETCH || state == ST_IDLE));

    // R8: fetch step only moves on an acknowledge
    a_r8_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH && !mem_ack) |=> $stable(fetch_idx));

    // R9: the completion pulse lasts one cycle
    a_r9_tc_single: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> !tc_pulse);

endmodule

// File: rtl/lldma_chan.sv
module lldma_chan
    import lldma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [2:0]        host_sel,
    input  logic [31:0]       host_wdata,
    input  logic              go,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [2:0]        mem_size,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic [ADDR_W-1:0] ptr_q,
    output logic [31:0]       ctrl_q,
    output logic [31:0]       cfg_q,
    output logic              tc_pulse
);

    lldma_state_e state;
    logic [1:0]   fetch_idx;
    logic         src_step, elem_done, en_clear, desc_we;
    logic         host_ok;
    logic [31:0]  elem_buf;

    assign host_ok = host_we && (state == ST_IDLE);

    lldma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (host_ok),
        .wr_sel    (host_sel),
        .wr_data   (host_wdata),
        .src_step  (src_step),
        .elem_done (elem_done),
        .en_clear  (en_clear),
        .desc_we   (desc_we),
        .desc_idx  (fetch_idx),
        .desc_data (mem_rdata),
        .src_r     (src_q),
        .dst_r     (dst_q),
        .ptr_r     (ptr_q),
        .ctrl_r    (ctrl_q),
        .cfg_r     (cfg_q)
    );

    lldma_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .chan_en   (cfg_q[EN_BIT]),
        .chan_halt (cfg_q[HALT_BIT]),
        .cnt_nz    (|ctrl_q[CNT_W-1:0]),
        .cnt_last  (ctrl_q[CNT_W-1:0] == CNT_W'(1)),
        .ptr_nz    (|ptr_q),
        .notify    (ctrl_q[NOTIFY_BIT]),
        .mem_ack   (mem_ack),
        .state     (state),
        .fetch_idx (fetch_idx),
        .src_step  (src_step),
        .elem_done (elem_done),
        .en_clear  (en_clear),
        .desc_we   (desc_we),
        .tc_pulse  (tc_pulse)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            elem_buf <= '0;
        else if (src_step)
            elem_buf <= mem_rdata;
    end

    always_comb begin
        mem_req   = (state != ST_IDLE);
        mem_we    = (state == ST_WRITE);
        mem_wdata = elem_buf;
        unique case (state)
            ST_READ: begin
                mem_addr = src_q;
                mem_size = ctrl_q[SW_LSB +: 3];
            end
            ST_WRITE: begin
                mem_addr = dst_q;
                mem_size = ctrl_q[DW_LSB +: 3];
            end
            ST_FETCH: begin
                mem_addr = ptr_q + ADDR_W'(desc_offset(fetch_idx));
                mem_size = 3'd2;
            end
            default: begin
                mem_addr = '0;
                mem_size = 3'd0;
            end
        endcase
    end

    // R7: the last element with a null pointer disables the channel
    a_r7_en_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE && mem_ack && ctrl_q[CNT_W-1:0] == CNT_W'(1) && ptr_q == '0)
        |=> !cfg_q[EN_BIT]);

    // R2: host writes are dropped while a request is outstanding
    a_r2_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && host_we && host_sel == SEL_CFG && !en_clear) |=> $stable(cfg_q));

    // R4: a request is held until it is acknowledged
    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

endmodule

// File: tb/lldma_chan_bench.sv
`timescale 1ns/1ps
module lldma_chan_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_sel = 3'd0;
    logic [31:0] host_wdata = '0;
    logic        go = 1'b0;
    logic        mem_req, mem_we, mem_ack, tc_pulse;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, src_q, dst_q, ptr_q, ctrl_q, cfg_q;
    logic [2:0]  mem_size;

    logic        stall = 1'b0;
    logic        ld_en = 1'b0;
    logic [8:0]  ld_addr = '0;
    logic [31:0] ld_word = '0;
    logic [7:0]  mem [512];
    int          tc_total = 0;
    int          rd_total = 0;
    logic [31:0] rd_log [32];
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    lldma_chan u_lldma_chan (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .go(go), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .src_q(src_q), .dst_q(dst_q),
        .ptr_q(ptr_q), .ctrl_q(ctrl_q), .cfg_q(cfg_q), .tc_pulse(tc_pulse)
    );

    function automatic logic [7:0] init_byte(input int a);
        return 8'((a * 13 + 5) & 255);
    endfunction

    // Memory model: one-cycle acknowledge, little-endian byte lanes.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            for (int a = 0; a < 512; a++) mem[a] <= init_byte(a);
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack && !stall) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    for (int b = 0; b < 4; b++)
                        if (b < (1 << mem_size)) mem[9'(mem_addr + 32'(b))] <= mem_wdata[8*b +: 8];
                end else begin
                    logic [31:0] w;
                    w = '0;
                    for (int b = 0; b < 4; b++)
                        if (b < (1 << mem_size)) w[8*b +: 8] = mem[9'(mem_addr + 32'(b))];
                    mem_rdata <= w;
                    rd_log[rd_total % 32] <= mem_addr;
                    rd_total <= rd_total + 1;
                end
            end
            if (ld_en)
                for (int b = 0; b < 4; b++) mem[ld_addr + 9'(b)] <= ld_word[8*b +: 8];
            if (tc_pulse) tc_total <= tc_total + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic ld_mem(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a; ld_word = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    function automatic logic [31:0] mk_ctrl(input logic irq, input logic di, input logic si,
                                             input logic [1:0] dw, input logic [1:0] sw,
                                             input logic [11:0] n);
        return {irq, 3'b000, di, si, 2'b00, 1'b0, dw, 1'b0, sw, 6'h2A, n};
    endfunction

    function automatic logic [31:0] mem_word(input int a, input int nb);
        logic [31:0] w;
        w = '0;
        for (int b = 0; b < 4; b++) if (b < nb) w[8*b +: 8] = mem[(a + b) % 512];
        return w;
    endfunction

    task automatic run_to_done(input int limit);
        go = 1'b1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (!cfg_q[0]) break;
        end
        go = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic count_req(input int cycles, output int seen);
        seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (mem_req) seen++;
        end
    endtask

    typedef struct packed {
        logic [11:0] n;
        logic [1:0]  sw;
        logic [1:0]  dw;
        logic        si;
        logic        di;
        logic        irq;
        logic [15:0] src;
        logic [15:0] dst;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{12'd1, 2'd2, 2'd2, 1'b1, 1'b1, 1'b1, 16'h0010, 16'h0100},
        '{12'd4, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 16'h0020, 16'h0110},
        '{12'd3, 2'd1, 2'd1, 1'b1, 1'b0, 1'b1, 16'h0030, 16'h0120},
        '{12'd3, 2'd2, 2'd2, 1'b0, 1'b1, 1'b0, 16'h0040, 16'h0130},
        '{12'd2, 2'd0, 2'd2, 1'b1, 1'b1, 1'b1, 16'h0050, 16'h0140},
        '{12'd2, 2'd2, 2'd0, 1'b1, 1'b1, 1'b0, 16'h0060, 16'h0150}
    };

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog (all R) actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seen, tc0, r0, sstep, dstep, nb_s, nb_d;
        logic [31:0] c, exp_w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 src", src_q, 0); chk("R1 dst", dst_q, 0); chk("R1 ptr", ptr_q, 0);
        chk("R1 ctrl", ctrl_q, 0); chk("R1 cfg", cfg_q, 0);
        chk("R1 req", 32'(mem_req), 0); chk("R1 tc", 32'(tc_pulse), 0);

        // Table of single-segment transfers: R4 R5 R6 R7 R9
        for (int v = 0; v < NV; v++) begin
            c = mk_ctrl(VECS[v].irq, VECS[v].di, VECS[v].si, VECS[v].dw, VECS[v].sw, VECS[v].n);
            wr_reg(3'd0, 32'(VECS[v].src));
            wr_reg(3'd1, 32'(VECS[v].dst));
            wr_reg(3'd2, 0);
            wr_reg(3'd3, c);
            wr_reg(3'd4, 32'h0000_00F1);
            tc0 = tc_total;
            run_to_done(2000);
            nb_s = 1 << VECS[v].sw; nb_d = 1 << VECS[v].dw;
            sstep = VECS[v].si ? nb_s : 0; dstep = VECS[v].di ? nb_d : 0;
            chk("R5 src end", src_q, 32'(VECS[v].src) + 32'(VECS[v].n) * 32'(sstep));
            chk("R5 dst end", dst_q, 32'(VECS[v].dst) + 32'(VECS[v].n) * 32'(dstep));
            chk("R6 ctrl end", ctrl_q, {c[31:12], 12'd0});
            chk("R7 cfg end", cfg_q, 32'h0000_00F0);
            chk("R9 tc count", 32'(tc_total - tc0), 32'(VECS[v].irq));
            exp_w = '0;
            for (int b = 0; b < 4; b++)
                if (b < nb_d && b < nb_s)
                    exp_w[8*b +: 8] = init_byte(int'(VECS[v].src) + (int'(VECS[v].n) - 1) * sstep + b);
            chk("R4 last element data",
                mem_word(int'(VECS[v].dst) + (int'(VECS[v].n) - 1) * dstep, nb_d), exp_w);
        end

        // R3: halted channel does not start, then runs once halt is cleared
        wr_reg(3'd0, 32'h80); wr_reg(3'd1, 32'h180);
        wr_reg(3'd3, mk_ctrl(1'b0, 1'b1, 1'b1, 2'd2, 2'd2, 12'd2));
        wr_reg(3'd4, 32'h0004_0001);
        go = 1'b1;
        count_req(20, seen);
        go = 1'b0;
        chk("R3 halt blocks", 32'(seen), 0);
        wr_reg(3'd4, 32'h0000_0001);
        count_req(20, seen);
        chk("R3 go low blocks", 32'(seen), 0);
        run_to_done(2000);
        chk("R3 resumed count", 32'(ctrl_q[11:0]), 0);

        // R3: zero count does nothing and keeps enable
        wr_reg(3'd3, mk_ctrl(1'b0, 1'b1, 1'b1, 2'd2, 2'd2, 12'd0));
        wr_reg(3'd4, 32'h0000_0001);
        go = 1'b1;
        count_req(20, seen);
        go = 1'b0;
        chk("R3 zero count no req", 32'(seen), 0);
        chk("R3 zero count keeps enable", cfg_q, 32'h1);

        // R2: write accepted in IDLE, ignored while a request is outstanding
        stall = 1'b1;
        wr_reg(3'd0, 32'h10);
        chk("R2 idle write", src_q, 32'h10);
        wr_reg(3'd1, 32'h190);
        wr_reg(3'd3, mk_ctrl(1'b0, 1'b1, 1'b1, 2'd2, 2'd2, 12'd1));
        wr_reg(3'd4, 32'h1);
        go = 1'b1;
        repeat (3) @(negedge clk);
        go = 1'b0;
        chk("R2 request pending", 32'(mem_req), 1);
        wr_reg(3'd0, 32'hABC);
        chk("R2 busy write ignored", src_q, 32'h10);
        stall = 1'b0;
        run_to_done(2000);
        chk("R2 src after run", src_q, 32'h14);

        // R8 R9: chained run, old ctrl notify=1, new ctrl notify=0
        ld_mem(9'h1C0, 32'h70);
        ld_mem(9'h1C4, 32'h160);
        ld_mem(9'h1C8, 32'h0);
        ld_mem(9'h1CC, mk_ctrl(1'b0, 1'b1, 1'b1, 2'd2, 2'd2, 12'd2));
        wr_reg(3'd0, 32'h80); wr_reg(3'd1, 32'h170); wr_reg(3'd2, 32'h1C0);
        wr_reg(3'd3, mk_ctrl(1'b1, 1'b1, 1'b1, 2'd2, 2'd2, 12'd1));
        wr_reg(3'd4, 32'h1);
        tc0 = tc_total; r0 = rd_total;
        run_to_done(4000);
        chk("R8 read count", 32'(rd_total - r0), 7);
        chk("R8 read 0 element", rd_log[(r0 + 0) % 32], 32'h80);
        chk("R8 fetch +0", rd_log[(r0 + 1) % 32], 32'h1C0);
        chk("R8 fetch +4", rd_log[(r0 + 2) % 32], 32'h1C4);
        chk("R8 fetch +12", rd_log[(r0 + 3) % 32], 32'h1CC);
        chk("R8 fetch +8", rd_log[(r0 + 4) % 32], 32'h1C8);
        chk("R8 reloaded src used", rd_log[(r0 + 5) % 32], 32'h70);
        chk("R8 src end", src_q, 32'h78);
        chk("R8 dst end", dst_q, 32'h168);
        chk("R8 ptr end", ptr_q, 32'h0);
        chk("R8 ctrl end", ctrl_q, {mk_ctrl(1'b0, 1'b1, 1'b1, 2'd2, 2'd2, 12'd0)});
        chk("R8 second segment data", mem_word(32'h164, 4), mem_word(32'h74, 4));
        chk("R9 notify from new ctrl (none)", 32'(tc_total - tc0), 0);

        // R9: old ctrl notify=0, reloaded ctrl notify=1 -> two pulses
        ld_mem(9'h1C0, 32'h90);
        ld_mem(9'h1C4, 32'h1A0);
        ld_mem(9'h1C8, 32'h0);
        ld_mem(9'h1CC, mk_ctrl(1'b1, 1'b1, 1'b1, 2'd2, 2'd2, 12'd1));
        wr_reg(3'd0, 32'hA0); wr_reg(3'd1, 32'h1B0); wr_reg(3'd2, 32'h1C0);
        wr_reg(3'd3, mk_ctrl(1'b0, 1'b1, 1'b1, 2'd2, 2'd2, 12'd1));
        wr_reg(3'd4, 32'h1);
        tc0 = tc_total;
        run_to_done(4000);
        chk("R9 notify from new ctrl (two)", 32'(tc_total - tc0), 2);
        chk("R9 tc low after", 32'(tc_pulse), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule